// File: doc/BRIEF.md
# Utilization-Driven Burst Decision Unit

This unit decides when the graphics clock should be asked to enter or leave its high-frequency burst mode. At each sampling instant it captures one utilization sample, the status word and the threshold. One cycle later it evaluates them. The sampling instant comes either from an external tick or from an internal divider, and the period is nominally 5 ms.

The unit keeps a ring of the most recent utilization samples and takes the largest of them as its load figure. How it compares that figure with the threshold depends on whether burst is currently active, which the status word reports. When the fuse bit says burst is not available, the utilization path is bypassed. An active burst is then always asked to stop.

Requests leave the unit as single-cycle pulses, which drive the sequencer that writes the control register. After a pulse, no further request is made until the sequencer acknowledges the previous one.

Top module: `burst_decider`

## Requirements
- R1: After reset, `enter_req_o` and `exit_req_o` are low and the sample window holds no valid entries.
- R2: A tick seen at clock edge N is evaluated, and any request is visible as a one-cycle pulse after edge N+1. Each evaluation yields at most one pulse, and `enter_req_o` and `exit_req_o` are never high together.
- R3: The load figure is the maximum of the last WIN (default 10) samples. Until WIN samples have arrived, only the samples received so far count.
- R4: The burst state comes from status bits 27:24: 4'b0001 means active and 4'b0000 means inactive. When status bit 31 is 1, the state is inactive and the load figure is strictly greater than the threshold, an entry request is issued. When the load figure equals the threshold, no request is issued.
- R5: When burst is active, status bit 31 is 1 and the load figure is strictly below the threshold, an exit request is issued. When the load figure equals the threshold, no request is issued.
- R6: When status bit 31 is 0, burst is prohibited and no utilization decision is made. If the state is active, an exit request is issued regardless of load. Otherwise nothing is issued.
- R7: A status field at bits 27:24 other than 4'b0000 or 4'b0001 issues no request when bit 31 is 1.
- R8: After a request, later evaluations issue nothing until `ack_i` has been high for a cycle.
- R9: The threshold is captured only on a tick. Changing `thresh_i` between ticks changes no output until the next evaluation.
- R10: With USE_INT_TICK=1, evaluations occur every TICK_DIV clock cycles and `tick_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sampling instant (external tick mode) |
| util_i | input | UTIL_W | Utilization sample |
| status_i | input | 32 | Status word: bit 31 is the fuse-available bit, bits 27:24 are the current request field |
| thresh_i | input | UTIL_W | Utilization threshold |
| ack_i | input | 1 | Acknowledge of the outstanding request |
| enter_req_o | output | 1 | Burst entry request pulse |
| exit_req_o | output | 1 | Burst exit request pulse |

## Verification
The main instance is built with the default WIN of 10 and an external tick, so the bench places every evaluation itself. This lets it push a large sample through more than ten evaluations and observe the exact evaluation at which it leaves the window. A second instance uses USE_INT_TICK=1 with TICK_DIV of 8, so the spacing of free-running evaluations is measurable within a few dozen cycles. That instance holds a prohibited-but-active status and a permanently high acknowledge, so an exit pulse appears at every evaluation.

// File: rtl/burst_decider.sv
module burst_decider #(
  parameter int UTIL_W       = 8,
  parameter int WIN          = 10,
  parameter bit USE_INT_TICK = 1'b0,
  parameter int TICK_DIV     = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [UTIL_W-1:0] util_i,
  input  logic [31:0]       status_i,
  input  logic [UTIL_W-1:0] thresh_i,
  input  logic              ack_i,
  output logic              enter_req_o,
  output logic              exit_req_o
);
  localparam int PW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int CW = $clog2(WIN + 1);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tick_w;

  generate
    if (USE_INT_TICK) begin : g_div
      logic [DW-1:0] div_q;
      logic          unused_tick;
      assign unused_tick = tick_i;
      assign tick_w = (div_q == DW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_w) div_q <= '0;
        else             div_q <= div_q + 1'b1;
      end
    end else begin : g_ext
      assign tick_w = tick_i;
    end
  endgenerate

  logic [UTIL_W-1:0] win_q [WIN];
  logic [PW-1:0]     wptr_q;
  logic [CW-1:0]     fill_q;
  logic              eval_q, fuse_q, pend_q;
  logic [3:0]        field_q;
  logic [UTIL_W-1:0] thr_q, win_max;
  logic              unused_status;

  assign unused_status = ^{status_i[30:28], status_i[23:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win_q[i] <= '0;
      wptr_q  <= '0;
      fill_q  <= '0;
      fuse_q  <= 1'b0;
      field_q <= '0;
      thr_q   <= '0;
    end else if (tick_w) begin
      win_q[wptr_q] <= util_i;
      wptr_q  <= (wptr_q == PW'(WIN - 1)) ? '0 : wptr_q + 1'b1;
      fill_q  <= (fill_q == CW'(WIN)) ? fill_q : fill_q + 1'b1;
      fuse_q  <= status_i[31];
      field_q <= status_i[27:24];
      thr_q   <= thresh_i;
    end
  end

  always_comb begin
    win_max = '0;
    for (int i = 0; i < WIN; i++)
      if (i < int'(fill_q) && win_q[i] > win_max) win_max = win_q[i];
  end

  wire active     = (field_q == 4'b0001);
  wire idle       = (field_q == 4'b0000);
  wire want_enter = fuse_q && idle && (win_max > thr_q);
  wire want_exit  = active && (!fuse_q || (win_max < thr_q));
  wire issue      = eval_q && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eval_q      <= 1'b0;
      pend_q      <= 1'b0;
      enter_req_o <= 1'b0;
      exit_req_o  <= 1'b0;
    end else begin
      eval_q      <= tick_w;
      enter_req_o <= issue && want_enter;
      exit_req_o  <= issue && want_exit;
      if (issue && (want_enter || want_exit)) pend_q <= 1'b1;
      else if (ack_i)                         pend_q <= 1'b0;
    end
  end
endmodule

module burst_decider_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [31:0] status,
  input logic        ack,
  input logic        en,
  input logic        ex
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n)        outstanding <= 1'b0;
    else if (ack)      outstanding <= 1'b0;
    else if (en || ex) outstanding <= 1'b1;
  end

  assert_never_both_R2: assert property (@(posedge clk) disable iff (!rst_n) !(en && ex));
  assert_one_wide_R2: assert property (@(posedge clk) disable iff (!rst_n) (en || ex) |=> !(en || ex));
  assert_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n) (en || ex) |-> $past(tick, 2));
  assert_enter_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($past(status[31], 2) && $past(status[27:24], 2) == 4'b0000));
  assert_exit_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ex |-> ($past(status[27:24], 2) == 4'b0001));
  assert_no_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n) outstanding |-> !(en || ex));
endmodule

bind burst_decider burst_decider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .status(status_i), .ack(ack_i),
  .en(enter_req_o), .ex(exit_req_o)
);

// File: tb/tb_burst_decider.sv
module tb_burst_decider;
  localparam int UW = 8;
  localparam int WIN = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ack = 1'b0;
  logic [UW-1:0] util = '0, thresh = '0;
  logic [31:0] status = '0;
  logic en, ex, div_en, div_ex;

  always #5 clk = ~clk;

  burst_decider #(.UTIL_W(UW), .WIN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .util_i(util), .status_i(status),
    .thresh_i(thresh), .ack_i(ack), .enter_req_o(en), .exit_req_o(ex));

  burst_decider #(.UTIL_W(UW), .WIN(WIN), .USE_INT_TICK(1'b1), .TICK_DIV(8)) dut_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .util_i('0), .status_i(32'h0100_0000),
    .thresh_i('0), .ack_i(1'b1), .enter_req_o(div_en), .exit_req_o(div_ex));

  int checks = 0, errors = 0, cyc = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];
  int win_m[$];
  bit pend_m = 0;
  logic td1 = 0, td2 = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string act, string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    td1 <= rst_n && tick;
    td2 <= td1;
  end

  always @(negedge clk) begin
    if (rst_n && td2 && exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({en, ex} == e, t, $sformatf("en=%0b ex=%0b", en, ex),
            $sformatf("en=%0b ex=%0b", e[1], e[0]));
    end else if (rst_n && (en || ex)) begin
      check(1'b0, "R2", $sformatf("unexpected en=%0b ex=%0b", en, ex), "no pulse");
    end
  end

  task automatic evaluate(int u, logic [31:0] st, int th, bit do_ack, string tag);
    int mx = 0;
    bit fuse, act, idle, e, x;
    win_m.push_back(u);
    if (win_m.size() > WIN) void'(win_m.pop_front());
    foreach (win_m[k]) if (win_m[k] > mx) mx = win_m[k];
    fuse = st[31];
    act  = (st[27:24] == 4'b0001);
    idle = (st[27:24] == 4'b0000);
    e = fuse && idle && (mx > th);
    x = act && (!fuse || mx < th);
    if (pend_m) begin e = 0; x = 0; end
    if (e || x) pend_m = 1;
    exp_q.push_back({e, x});
    tag_q.push_back(tag);
    @(negedge clk);
    tick = 1; util = UW'(u); status = st; thresh = UW'(th);
    @(negedge clk);
    tick = 0;
    @(negedge clk);
    if (do_ack && (e || x)) begin
      ack = 1; pend_m = 0;
      @(negedge clk);
      ack = 0;
    end
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack = 1; pend_m = 0;
    @(negedge clk); ack = 0;
  endtask

  localparam logic [31:0] IDLE = 32'h8000_0000;
  localparam logic [31:0] ACT  = 32'h8100_0000;

  initial begin
    repeat (3) @(negedge clk);
    check(en == 0 && ex == 0, "R1", $sformatf("%0b%0b", en, ex), "00");
    rst_n = 1;
    @(negedge clk);
    check(en == 0 && ex == 0, "R1", $sformatf("%0b%0b", en, ex), "00");

    evaluate(10, IDLE, 50, 1, "R3 partial window");
    evaluate(80, IDLE, 50, 0, "R4 enter");
    evaluate(90, IDLE, 50, 0, "R8 pending blocks");
    ack_pulse();
    evaluate(20, IDLE, 50, 1, "R3 window max enter");
    for (int i = 0; i < 9; i++) evaluate(5, ACT, 50, 1, "R3 R5 window ageing");
    evaluate(50, ACT, 50, 1, "R5 equal no exit");
    evaluate(50, IDLE, 50, 1, "R4 equal no enter");
    evaluate(200, 32'h0100_0000, 250, 1, "R6 prohibited active exit");
    evaluate(200, 32'h0000_0000, 50, 1, "R6 prohibited idle");
    evaluate(200, 32'h8300_0000, 50, 1, "R7 reserved high");
    evaluate(0, 32'h8300_0000, 250, 1, "R7 reserved low");
    evaluate(0, IDLE, 250, 1, "R9 threshold above");
    @(negedge clk); thresh = 8'd100;
    repeat (5) @(negedge clk);
    check(en == 0 && ex == 0, "R9", $sformatf("%0b%0b", en, ex), "00 before next tick");
    evaluate(0, IDLE, 100, 1, "R9 new threshold enter");

    begin
      int t0;
      while (!div_ex) @(negedge clk);
      t0 = cyc;
      @(negedge clk);
      while (!div_ex) @(negedge clk);
      check(cyc - t0 == 8, "R10", $sformatf("%0d", cyc - t0), "8");
      check(div_en == 0, "R10", $sformatf("%0b", div_en), "0");
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", $sformatf("%0d left", exp_q.size()), "0 left");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule